// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This block takes one fixed-point element, shifts it right by an amount given at run time, and rounds the result. The element width can be 8, 16, 32 or 64 bits, and it is chosen per operation. An unsigned operation shifts in zeros. A signed operation first extends the sign bit of the chosen width, then shifts arithmetically.

The rounding increment comes from three bits: the last bit shifted out (the guard), the OR of every bit below the guard (the sticky), and the least significant bit of the truncated value. One of four rounding rules turns these into the increment. The increment is added to the shifted value with wraparound, and the output keeps only the low element-width bits.

The unit has one register stage. An operation presented with `inValid` high in one cycle appears on `result`, together with `outValid`, after the next rising clock edge. A small control module decodes the select inputs into a struct of strobes. The datapath module does the extension, the shift, the rounding and the output register.

Top module: `fxp_round_shifter`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `outValid` is 0 and `result` is 0.
- R2: `outValid` in a cycle equals `inValid` sampled at the previous rising edge. When `inValid` was 1, `result` holds that operation's answer. When `inValid` was 0, `result` keeps its previous value.
- R3: The `widthSel` encoding is 00 = 8 bits, 01 = 16 bits, 10 = 32 bits and 11 = 64 bits. Only the low element-width bits of `operand` are used. Every `result` bit above the element width is 0.
- R4: Only the low log2(width) bits of `shiftAmt` are used, so the effective shift is `shiftAmt` modulo the width and lies in 0 to width−1.
- R5: With an effective shift of 0, `result` equals the element-width bits of `operand` in every rounding mode and for both signedness settings.
- R6: With `signedSel` = 0 the shift is logical on the zero-extended element. With `signedSel` = 1 the element is sign-extended from bit width−1 before an arithmetic shift.
- R7: `roundSel` = 00 (round to nearest, ties up): the increment equals the guard bit, which is operand bit (shift−1).
- R8: `roundSel` = 01 (round to nearest, ties to even): the increment is the guard bit AND (sticky OR truncated LSB). The sticky bit is the OR of the operand bits below the guard bit, and it is 0 for a shift of 1.
- R9: `roundSel` = 10 (round down): the increment is always 0, so `result` is the truncated shifted value.
- R10: `roundSel` = 11 (round to odd): the increment is 1 only when the truncated LSB is 0 and the guard or sticky bit is 1.
- R11: The increment is added modulo 2 to the power of the width. For example, a signed 8-bit 0xFF shifted by 1 with `roundSel` = 00 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| operand | input | 64 | Element to shift; only the low width bits are used |
| shiftAmt | input | 6 | Right shift amount, reduced modulo the width |
| widthSel | input | 2 | Element width select (00/01/10/11 = 8/16/32/64) |
| roundSel | input | 2 | Rounding mode (00 up, 01 even, 10 down, 11 odd) |
| signedSel | input | 1 | 1 = arithmetic shift of a signed element |
| outValid | output | 1 | `result` holds the answer to the previous cycle's operation |
| result | output | 64 | Rounded, shifted element, zero above the width |

## Verification
The assertions assume that `widthSel`, `roundSel` and `signedSel` are known values whenever `inValid` is high. They also assume that the strobes from the control module stay consistent within the cycle in which they are registered. The bench drives every select from a fixed encoding, and it changes inputs only on falling edges, so every captured operation has defined, stable selects. The stimulus covers raw shift amounts larger than the width, so that the modulo reduction is exercised, and it does not depend on `shiftAmt` already being in range.

// File: rtl/fxp_rs_pkg.sv
package fxp_rs_pkg;

  localparam int unsigned MAX_W   = 64;
  localparam int unsigned SH_W    = $clog2(MAX_W);
  localparam int unsigned NUM_W   = 4;
  localparam int unsigned MIN_LOG = 3;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'b00,
    RM_NEAR_EVEN = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ODD       = 2'b11
  } roundMode_e;

  typedef struct packed {
    logic             load;
    logic [NUM_W-1:0] widthHot;
    logic [SH_W-1:0]  shift;
    logic             shiftZero;
    logic             arith;
    logic             incNearUp;
    logic             incNearEven;
    logic             incOdd;
  } ctrlStrobes_t;

endpackage

// File: rtl/fxp_rs_ctrl.sv
module fxp_rs_ctrl
  import fxp_rs_pkg::*;
(
  input  logic             inValid,
  input  logic [SH_W-1:0]  shiftAmt,
  input  logic [1:0]       widthSel,
  input  logic [1:0]       roundSel,
  input  logic             signedSel,
  output ctrlStrobes_t     strobes
);

  logic [NUM_W-1:0] widthHot;
  logic [SH_W-1:0]  shiftMaskPer [NUM_W];
  logic [SH_W-1:0]  shiftMask;
  logic [SH_W-1:0]  shiftEff;
  roundMode_e       mode;

  // One decoder output and one shift mask for each supported width
  for (genvar k = 0; k < NUM_W; k++) begin : g_width
    localparam int unsigned LOGW = MIN_LOG + k;
    localparam logic [SH_W-1:0] SHM = SH_W'((1 << LOGW) - 1);
    assign widthHot[k]     = (widthSel == 2'(k));
    assign shiftMaskPer[k] = widthHot[k] ? SHM : '0;
  end

  always_comb begin
    shiftMask = '0;
    for (int k = 0; k < NUM_W; k++) begin
      shiftMask = shiftMask | shiftMaskPer[k];
    end
  end

  assign shiftEff = shiftAmt & shiftMask;
  assign mode     = roundMode_e'(roundSel);

  always_comb begin
    strobes             = '0;
    strobes.load        = inValid;
    strobes.widthHot    = widthHot;
    strobes.shift       = shiftEff;
    strobes.shiftZero   = (shiftEff == '0);
    strobes.arith       = signedSel;
    unique case (mode)
      RM_NEAR_UP:   strobes.incNearUp   = 1'b1;
      RM_NEAR_EVEN: strobes.incNearEven = 1'b1;
      RM_ODD:       strobes.incOdd      = 1'b1;
      default:      ;
    endcase
  end

endmodule

// File: rtl/fxp_rs_datapath.sv
module fxp_rs_datapath
  import fxp_rs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MAX_W-1:0] operand,
  input  ctrlStrobes_t     strobes,
  output logic             outValid,
  output logic [MAX_W-1:0] result
);

  logic [MAX_W-1:0] extPer  [NUM_W];
  logic [MAX_W-1:0] maskPer [NUM_W];
  logic [MAX_W-1:0] extSel;
  logic [MAX_W-1:0] sewMask;
  logic [MAX_W-1:0] shiftedLog;
  logic [MAX_W-1:0] shiftedAri;
  logic [MAX_W-1:0] shifted;
  logic [MAX_W-1:0] lowMask;
  logic [MAX_W-1:0] guardMask;
  logic [MAX_W-1:0] stickyMask;
  logic             guardBit;
  logic             stickyBit;
  logic             truncLsb;
  logic             incr;
  logic [MAX_W-1:0] sum;
  logic [MAX_W-1:0] resultNext;

  // Per-width extension: keep the element, fill above it with the sign or zero
  for (genvar k = 0; k < NUM_W; k++) begin : g_ext
    localparam int unsigned EW = 8 << k;
    localparam logic [MAX_W-1:0] EMASK = {MAX_W{1'b1}} >> (MAX_W - EW);
    logic fill;
    assign fill       = strobes.arith & operand[EW-1];
    assign maskPer[k] = strobes.widthHot[k] ? EMASK : '0;
    assign extPer[k]  = strobes.widthHot[k]
                        ? ((operand & EMASK) | (fill ? ~EMASK : '0))
                        : '0;
  end

  always_comb begin
    extSel  = '0;
    sewMask = '0;
    for (int k = 0; k < NUM_W; k++) begin
      extSel  = extSel  | extPer[k];
      sewMask = sewMask | maskPer[k];
    end
  end

  assign shiftedLog = extSel >> strobes.shift;
  assign shiftedAri = $unsigned($signed(extSel) >>> strobes.shift);
  assign shifted    = strobes.arith ? shiftedAri : shiftedLog;

  // Bits shifted out: lowMask covers them, the top one is the guard
  assign lowMask    = ~({MAX_W{1'b1}} << strobes.shift);
  assign stickyMask = lowMask >> 1;
  assign guardMask  = lowMask ^ stickyMask;
  assign guardBit   = |(extSel & guardMask);
  assign stickyBit  = |(extSel & stickyMask);
  assign truncLsb   = shifted[0];

  always_comb begin
    incr = 1'b0;
    if (!strobes.shiftZero) begin
      if (strobes.incNearUp)   incr = guardBit;
      if (strobes.incNearEven) incr = guardBit & (stickyBit | truncLsb);
      if (strobes.incOdd)      incr = ~truncLsb & (guardBit | stickyBit);
    end
  end

  assign sum        = shifted + MAX_W'(incr);
  assign resultNext = sum & sewMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) result <= resultNext;
    end
  end

  AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> ($countones(strobes.widthHot) == 1)); // R3

  AST_RESULT_IN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> ((result & ~$past(sewMask)) == '0)); // R3

  AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.shiftZero) |=> (result == $past(operand & sewMask))); // R5

  AST_DOWN_TRUNCATES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.incNearUp && !strobes.incNearEven && !strobes.incOdd)
      |=> (result == $past(shifted & sewMask))); // R9

  AST_ODD_LSB_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.incOdd && (guardBit || stickyBit)) |=> result[0]); // R10

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(strobes.load))); // R2

endmodule

// File: rtl/fxp_round_shifter.sv
module fxp_round_shifter
  import fxp_rs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [63:0]      operand,
  input  logic [5:0]       shiftAmt,
  input  logic [1:0]       widthSel,
  input  logic [1:0]       roundSel,
  input  logic             signedSel,
  output logic             outValid,
  output logic [63:0]      result
);

  ctrlStrobes_t strobes;

  fxp_rs_ctrl u_ctrl (
    .inValid   (inValid),
    .shiftAmt  (shiftAmt),
    .widthSel  (widthSel),
    .roundSel  (roundSel),
    .signedSel (signedSel),
    .strobes   (strobes)
  );

  fxp_rs_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .operand  (operand),
    .strobes  (strobes),
    .outValid (outValid),
    .result   (result)
  );

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R2

endmodule

// File: tb/tb_fxp_round_shifter.sv
`timescale 1ns/1ps
module tb_fxp_round_shifter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic [5:0]  shiftAmt = '0;
  logic [1:0]  widthSel = '0;
  logic [1:0]  roundSel = '0;
  logic        signedSel = 1'b0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        expValid = 1'b0;
  logic [63:0] expResult = '0;
  string       expTag = "R1";

  always #4 clk = ~clk;

  fxp_round_shifter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .shiftAmt(shiftAmt), .widthSel(widthSel), .roundSel(roundSel),
    .signedSel(signedSel), .outValid(outValid), .result(result)
  );

  function automatic logic [63:0] refModel(input logic [63:0] op, input int rawSh,
                                           input int w, input bit sgn, input int m);
    logic [127:0] v;
    logic [127:0] tr;
    logic [63:0]  r;
    bit g, st, lsb, inc;
    int s;
    s = rawSh % w;
    for (int i = 0; i < 128; i++) v[i] = (i < w) ? op[i] : (sgn & op[w-1]);
    tr  = v >> s;
    g   = (s > 0) ? v[s-1] : 1'b0;
    st  = 1'b0;
    for (int i = 0; i < s - 1; i++) st = st | v[i];
    lsb = tr[0];
    case (m)
      0: inc = g;
      1: inc = g & (st | lsb);
      2: inc = 1'b0;
      default: inc = ~lsb & (g | st);
    endcase
    tr = tr + 128'(inc);
    for (int i = 0; i < 64; i++) r[i] = (i < w) ? tr[i] : 1'b0;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: compare the previous cycle's outcome, then drive a new operation
  task automatic step(input bit v, input logic [63:0] op, input int sh, input int wsel,
                      input bit sgn, input int m, input string tag);
    @(negedge clk);
    check(outValid == expValid, "R2", 64'(outValid), 64'(expValid));
    if (expValid) check(result == expResult, expTag, result, expResult);
    inValid   = v;
    operand   = op;
    shiftAmt  = 6'(sh);
    widthSel  = 2'(wsel);
    roundSel  = 2'(m);
    signedSel = sgn;
    expValid  = v;
    if (v) begin
      expResult = refModel(op, sh, 8 << wsel, sgn, m);
      expTag    = tag;
    end
  endtask

  task automatic directed(input logic [63:0] op, input int sh, input int wsel,
                          input bit sgn, input int m, input logic [63:0] exp,
                          input string tag);
    step(1'b1, op, sh, wsel, sgn, m, tag);
    @(negedge clk);
    check(result == exp, tag, result, exp);
    inValid  = 1'b0;
    expValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    string mTag [4];
    mTag[0] = "R7"; mTag[1] = "R8"; mTag[2] = "R9"; mTag[3] = "R10";
    inValid = 1'b1; operand = 64'hDEAD; roundSel = 2'b00;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && result == '0, "R1", result, 64'h0);
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && result == '0, "R1", result, 64'h0);

    directed(64'h0000_0000_0000_00AB, 0, 0, 1'b0, 0, 64'hAB, "R5");
    directed(64'h0000_0000_0000_0080, 0, 0, 1'b1, 3, 64'h80, "R5");
    directed(64'h0B, 2, 0, 1'b0, 0, 64'h03, "R7");
    directed(64'h0A, 2, 0, 1'b0, 1, 64'h02, "R8");
    directed(64'h0E, 2, 0, 1'b0, 1, 64'h04, "R8");
    directed(64'h0B, 1, 0, 1'b0, 1, 64'h06, "R8");
    directed(64'h0B, 2, 0, 1'b0, 2, 64'h02, "R9");
    directed(64'h0B, 2, 0, 1'b0, 3, 64'h03, "R10");
    directed(64'h0D, 2, 0, 1'b0, 3, 64'h03, "R10");
    directed(64'h80, 3, 0, 1'b1, 2, 64'hF0, "R6");
    directed(64'h80, 3, 0, 1'b0, 2, 64'h10, "R6");
    directed(64'hFF, 1, 0, 1'b1, 0, 64'h00, "R11");
    directed(64'h0B, 9, 0, 1'b0, 2, 64'h05, "R4");
    directed(64'hFFFF_FFFF_FFFF_FF0B, 0, 0, 1'b0, 2, 64'h0B, "R3");
    directed(64'h0000_0000_0001_8000, 15, 1, 1'b1, 2, 64'hFFFF, "R3");
    directed(64'h8000_0000_0000_0000, 63, 3, 1'b1, 2, 64'hFFFF_FFFF_FFFF_FFFF, "R6");

    // Idle cycle: the value must be held
    step(1'b0, 64'h1234, 1, 0, 1'b0, 0, "R2");
    @(negedge clk);
    check(result == 64'hFFFF_FFFF_FFFF_FFFF, "R2", result, 64'hFFFF_FFFF_FFFF_FFFF);

    for (int m = 0; m < 4; m++) begin
      for (int ws = 0; ws < 4; ws++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int k = 0; k < 8; k++) begin
            int w;
            int sh;
            w = 8 << ws;
            case (k)
              0: sh = 0;
              1: sh = 1;
              2: sh = w - 1;
              3: sh = int'($urandom_range(63, 0));
              default: sh = int'($urandom_range(w - 1, 0));
            endcase
            step(1'b1, {$urandom, $urandom}, sh, ws, sg[0], m, mTag[m]);
            if (k == 5) step(1'b0, 64'h0, 0, 0, 1'b0, 0, "R2");
          end
        end
      end
    end
    step(1'b0, 64'h0, 0, 0, 1'b0, 0, "R2");
    step(1'b0, 64'h0, 0, 0, 1'b0, 0, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule